// File: doc/BRIEF.md
# Per-Port Jabber Watchdog

This block watches the transmit side of each attached station and stops a station that keeps sending far past any legal frame length. For every port it takes a qualified activity flag, which is high while a frame is being received on that port's transmit input. It measures how long each frame lasts. When one frame outlasts the trip limit, the port is latched into a jabber state. In that state the port's data is no longer forwarded, and the port's own collision output is forced on so that the collision generator signals the babbling station.

A latched port is released only after a continuous quiet interval. Any renewed activity during that interval starts the measurement again from zero. A single global disable input switches the protection off for all ports. Each port also has an active-low jabber status flag that follows the state with no stretching. Durations are counted in ticks from a shared prescaler. The prescaler divide ratio, the trip length and the quiet length are all parameters, so a simulation can run with short scaled values.

Top module: `jabber_watchdog`

## Requirements
- R1: After synchronous reset, every port has `fwd_en` high, `col_force` low and `jab_stat_n` high.
- R2: A port whose activity stays high without a break through TRIP_TICKS prescaler ticks enters jabber. The change is seen at the outputs on the clock edge that samples the last of those ticks.
- R3: In jabber, that port drives `fwd_en` low and `col_force` high. Its bit 0 of either vector belongs to port 0, and so on.
- R4: A jabbing port returns to forwarding, with `col_force` low, once its activity has stayed low without a break through QUIET_TICKS ticks.
- R5: Activity on a jabbing port during the quiet interval restarts the quiet count from zero, and the port stays in jabber.
- R6: While `jab_off` is high, no port enters jabber, and a port that is jabbing returns to forwarding on the next clock edge.
- R7: `jab_stat_n` of a port is low exactly while that port is in jabber, with no pulse stretching.
- R8: A drop in activity clears the frame-length count, so frames that are each shorter than the limit never trip the port.
- R9: Ports are independent: the jabber of one port leaves the other ports' outputs unchanged.
- R10: The prescaler emits one tick every TICK_DIV clock cycles, and all timing is counted in these ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jab_off | input | 1 | Global disable of jabber protection |
| tx_act | input | NPORTS | Qualified activity per port transmit input |
| fwd_en | output | NPORTS | High while the port's data may be forwarded |
| col_force | output | NPORTS | High while the port's collision output must be forced |
| jab_stat_n | output | NPORTS | Active-low jabber status per port |

## Verification
Activity and the disable input act on the first clock edge after they are driven. Reset and disable take effect on that edge. Trip and release take effect on the edge that samples the tick completing the count, and the tick itself is registered one cycle after the prescaler wraps. The bench keeps a behavioural model that advances on each rising edge from the same inputs, and it compares all three outputs of every port on every falling edge. The directed checks are placed at falling edges that lie whole tick periods beyond the trip or release points, so they sample settled values.

// File: rtl/jabwd_pkg.sv
package jabwd_pkg;
  typedef enum logic {
    ST_PASS = 1'b0,
    ST_JAB  = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jabwd_tick.sv
module jabwd_tick #(
  parameter int TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick    <= (div_cnt == LAST);
      div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_chk
      p_tick_spacing_r10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/jabwd_port.sv
module jabwd_port
  import jabwd_pkg::*;
#(
  parameter int TRIP_TICKS  = 14,
  parameter int QUIET_TICKS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic off,
  input  logic act,
  output logic jab
);
  localparam int RW = $clog2(TRIP_TICKS + 1);
  localparam int QW = $clog2(QUIET_TICKS + 1);
  localparam logic [RW-1:0] RUN_LAST   = RW'(TRIP_TICKS - 1);
  localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_TICKS - 1);

  jab_state_e    st;
  logic [RW-1:0] run_cnt;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || off) begin
      st        <= ST_PASS;
      run_cnt   <= '0;
      quiet_cnt <= '0;
    end else begin
      unique case (st)
        ST_PASS: begin
          if (!act) begin
            run_cnt <= '0;
          end else if (tick) begin
            if (run_cnt == RUN_LAST) begin
              st        <= ST_JAB;
              run_cnt   <= '0;
              quiet_cnt <= '0;
            end else begin
              run_cnt <= run_cnt + 1'b1;
            end
          end
        end
        ST_JAB: begin
          if (act) begin
            quiet_cnt <= '0;
          end else if (tick) begin
            if (quiet_cnt == QUIET_LAST) begin
              st        <= ST_PASS;
              quiet_cnt <= '0;
            end else begin
              quiet_cnt <= quiet_cnt + 1'b1;
            end
          end
        end
        default: st <= ST_PASS;
      endcase
    end
  end

  assign jab = (st == ST_JAB);

  p_trip_needs_act_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(jab) |-> ($past(act) && $past(tick)));
  p_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PASS) |-> (run_cnt < RW'(TRIP_TICKS)));
  p_release_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(jab) && !$past(off)) |-> !$past(act));
  p_quiet_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (jab && act && !off) |=> (jab && quiet_cnt == '0));
endmodule

// File: rtl/jabber_watchdog.sv
module jabber_watchdog #(
  parameter int NPORTS      = 2,
  parameter int TICK_DIV    = 200000,
  parameter int TRIP_TICKS  = 14,
  parameter int QUIET_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jab_off,
  input  logic [NPORTS-1:0] tx_act,
  output logic [NPORTS-1:0] fwd_en,
  output logic [NPORTS-1:0] col_force,
  output logic [NPORTS-1:0] jab_stat_n
);
  logic              tick;
  logic [NPORTS-1:0] jab;

  jabwd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      jabwd_port #(
        .TRIP_TICKS  (TRIP_TICKS),
        .QUIET_TICKS (QUIET_TICKS)
      ) u_port (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .off  (jab_off),
        .act  (tx_act[p]),
        .jab  (jab[p])
      );

      assign fwd_en[p]     = !jab[p];
      assign col_force[p]  = jab[p];
      assign jab_stat_n[p] = !jab[p];

      p_off_release_r6: assert property (@(posedge clk) disable iff (rst)
        jab_off |=> (fwd_en[p] && !col_force[p]));
      p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fwd_en[p] && jab_stat_n[p]));
    end
  endgenerate
endmodule

// File: tb/test_jabber_watchdog.sv
`timescale 1ns/1ps
module test_jabber_watchdog;
  localparam int NP    = 2;
  localparam int DIV   = 4;
  localparam int TRIP  = 5;
  localparam int QUIET = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          jab_off = 1'b0;
  logic [NP-1:0] tx_act = '0;
  logic [NP-1:0] fwd_en, col_force, jab_stat_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  jabber_watchdog #(
    .NPORTS(NP), .TICK_DIV(DIV), .TRIP_TICKS(TRIP), .QUIET_TICKS(QUIET)
  ) i_jabber_watchdog (
    .clk(clk), .rst(rst), .jab_off(jab_off), .tx_act(tx_act),
    .fwd_en(fwd_en), .col_force(col_force), .jab_stat_n(jab_stat_n)
  );

  // behavioural reference model
  int m_pc, m_tick;
  int m_st[NP], m_rc[NP], m_qc[NP];

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_tick = 0;
      for (int p = 0; p < NP; p++) begin m_st[p] = 0; m_rc[p] = 0; m_qc[p] = 0; end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (jab_off) begin
          m_st[p] = 0; m_rc[p] = 0; m_qc[p] = 0;
        end else if (m_st[p] == 0) begin
          if (!tx_act[p]) m_rc[p] = 0;
          else if (m_tick != 0) begin
            if (m_rc[p] == TRIP - 1) begin m_st[p] = 1; m_rc[p] = 0; m_qc[p] = 0; end
            else m_rc[p]++;
          end
        end else begin
          if (tx_act[p]) m_qc[p] = 0;
          else if (m_tick != 0) begin
            if (m_qc[p] == QUIET - 1) begin m_st[p] = 0; m_qc[p] = 0; end
            else m_qc[p]++;
          end
        end
      end
      m_tick = (m_pc == DIV - 1) ? 1 : 0;
      m_pc   = (m_pc == DIV - 1) ? 0 : m_pc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actv, expv, $time);
    end
  endtask

  // model compared on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int p = 0; p < NP; p++) begin
        chk(fwd_en[p] == (m_st[p] == 0), "R3 fwd_en vs model", fwd_en[p], m_st[p] == 0);
        chk(col_force[p] == (m_st[p] == 1), "R3 col_force vs model", col_force[p], m_st[p] == 1);
        chk(jab_stat_n[p] == (m_st[p] == 0), "R7 jab_stat_n vs model", jab_stat_n[p], m_st[p] == 0);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk(fwd_en == '1 && col_force == '0 && jab_stat_n == '1, "R1 reset state",
        {fwd_en, col_force}, 4'b1100);
    // R8: short frames below the limit never trip
    tx_act[0] = 1'b1; wait_cyc(3 * DIV);
    tx_act[0] = 1'b0; wait_cyc(2);
    tx_act[0] = 1'b1; wait_cyc(3 * DIV);
    tx_act[0] = 1'b0; wait_cyc(2);
    chk(fwd_en[0] == 1'b1, "R8 short frames no trip", fwd_en[0], 1);
    // R2: long frame trips
    tx_act[0] = 1'b1; wait_cyc((TRIP + 2) * DIV);
    chk(col_force[0] == 1'b1, "R2 trip after limit", col_force[0], 1);
    chk(fwd_en[0] == 1'b0, "R3 forwarding blocked", fwd_en[0], 0);
    chk(jab_stat_n[0] == 1'b0, "R7 status low in jabber", jab_stat_n[0], 0);
    chk(fwd_en[1] == 1'b1 && col_force[1] == 1'b0, "R9 other port untouched", col_force[1], 0);
    wait_cyc(10 * DIV);
    chk(col_force[0] == 1'b1, "R2 stays in jabber while active", col_force[0], 1);
    // R5: renewed activity restarts quiet count
    tx_act[0] = 1'b0; wait_cyc(5 * DIV);
    tx_act[0] = 1'b1; wait_cyc(1);
    tx_act[0] = 1'b0; wait_cyc((QUIET - 2) * DIV);
    chk(col_force[0] == 1'b1, "R5 quiet restarted", col_force[0], 1);
    // R4: release after full quiet interval
    wait_cyc(4 * DIV);
    chk(fwd_en[0] == 1'b1 && col_force[0] == 1'b0, "R4 release after quiet", fwd_en[0], 1);
    chk(jab_stat_n[0] == 1'b1, "R7 status high after release", jab_stat_n[0], 1);
    // R9 / R6: both ports jab, then disable
    tx_act = '1; wait_cyc((TRIP + 2) * DIV);
    chk(col_force == '1, "R9 both ports jab", col_force, 3);
    jab_off = 1'b1; wait_cyc(1);
    chk(fwd_en == '1 && col_force == '0, "R6 disable releases next edge", col_force, 0);
    wait_cyc((TRIP + 4) * DIV);
    chk(col_force == '0, "R6 no trip while disabled", col_force, 0);
    jab_off = 1'b0; wait_cyc((TRIP + 2) * DIV);
    chk(col_force == '1, "R2 trip resumes after enable", col_force, 3);
    tx_act = '0; wait_cyc((QUIET + 2) * DIV);
    chk(fwd_en == '1, "R4 both released", fwd_en, 3);
    // R10 indirectly: trip time bounded by tick count
    tx_act[1] = 1'b1; wait_cyc((TRIP - 1) * DIV - 2);
    chk(col_force[1] == 1'b0, "R10 no trip before tick count", col_force[1], 0);
    wait_cyc(3 * DIV);
    chk(col_force[1] == 1'b1, "R10 trip after tick count", col_force[1], 1);
    tx_act = '0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule